// File: doc/BRIEF.md
# Selectable Pseudo-Random Pattern Generator and Error Checker

This block is a self-test engine for the parallel data path of a serial link. Its generator emits one word of test pattern per cycle. The pattern can be one of four pseudo-random sequences of increasing length, an alternating one/zero toggle pattern or a fixed word loaded by software. The generator advances by the full word width on every cycle.

The checker receives one word per cycle, either from the link's receive path or, when loopback is selected, directly from the generator. It takes its starting state from the incoming bits, with no seed exchange between the two ends. It then predicts every following word, declares lock after a run of clean words, and accumulates mismatched bits into a saturating counter for bit-error-rate measurement. An injection input flips a single bit so that the counting path can be proven.

Word bit order: bit DW-1 of a word is the oldest bit of the sequence and bit 0 the newest. Pattern codes on `mode`: 0 = order 7 (x^7+x^6+1), 1 = order 15 (x^15+x^14+1), 2 = order 23 (x^23+x^18+1), 3 = order 31 (x^31+x^28+1), 4 = toggle pattern, 5 to 7 = user word. For a sequence, each new bit is the XOR of the two tapped state bits. That bit is also the output bit and is shifted into bit 0 of the state.

Top module: `prbs_bist`

## Requirements
- R1: After reset, and on the cycle after any cycle with `gen_en` low, `tx_data` is zero. After reset `locked` is 0 and `err_count` is 0.
- R2: With `gen_en` high and codes 0 to 3, `tx_data` carries DW consecutive sequence bits per cycle, MSB oldest. The first word after enable is generated from `seed` masked to the order, and each later word continues the sequence.
- R3: A PRBS seed that is zero after masking is replaced by the state value 1.
- R4: Code 4 produces an alternating pattern whose first bit is 1, so for even DW every word is 1010...10 (0xAAAA for 16 bits).
- R5: Codes 5 to 7 repeat `user_word` on every cycle.
- R6: When `loopback` is 1 the checker takes `tx_data` as its input. When it is 0 the checker takes `rx_data`.
- R7: After a (re)start the checker consumes ceil(order/DW) words as seed (one word for codes 4 to 7) without comparing them. A seed that is all zero in a PRBS mode is rejected and seeding continues, so an all-zero stream never locks.
- R8: `locked` rises after the 16th consecutive error-free compared word. With the start edge counted as edge 0, it is visible after edge seed_words+16.
- R9: Four consecutive compared words that each contain an error clear `locked` and return the checker to seeding. Fewer than four followed by a clean word leave lock unchanged.
- R10: Each compared word adds its number of mismatched bits to `err_count`, but only while `locked` was 1 before that word. Errors before lock add nothing.
- R11: `err_count` saturates at all ones. `err_clr` zeroes it on the next edge and takes priority over a same-cycle addition.
- R12: A high `inject_err` on a generating cycle inverts bit 0 of the next `tx_data` word only, without disturbing the sequence. In loopback, exactly one error is counted.
- R13: Raising an enable, or changing `mode` while enabled, restarts the affected generator from `seed` and the checker from seeding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gen_en | input | 1 | Generator enable |
| chk_en | input | 1 | Checker enable |
| mode | input | 3 | Pattern code, shared by generator and checker |
| seed | input | 31 | Generator start state, masked to the order |
| user_word | input | DW | Word repeated in user mode |
| inject_err | input | 1 | Invert bit 0 of the next generated word |
| loopback | input | 1 | Feed generator output into the checker |
| rx_data | input | DW | Received word |
| err_clr | input | 1 | Clear the error counter |
| tx_data | output | DW | Generated word |
| locked | output | 1 | Checker lock status |
| err_count | output | CW | Saturating mismatched-bit count |

## Verification
The properties assume that `user_word` is held steady while user mode is generating and compared in loopback, and that `inject_err` is low whenever a property predicts the exact generated word. The stimulus changes `user_word` only while the engine is in a PRBS mode. It pulses `inject_err` once per injection test, and it applies `mode` and the enables only at falling edges, so a restart always lines up with a single known clock edge.

// File: rtl/prbs_bist_pkg.sv
`timescale 1ns/1ps
package prbs_bist_pkg;
  localparam int STW = 31;

  localparam logic [2:0] PAT_P7  = 3'd0;
  localparam logic [2:0] PAT_P15 = 3'd1;
  localparam logic [2:0] PAT_P23 = 3'd2;
  localparam logic [2:0] PAT_P31 = 3'd3;
  localparam logic [2:0] PAT_TGL = 3'd4;

  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_SEED = 2'd1, PH_TRACK = 2'd2} chk_ph_e;

  function automatic logic pat_is_prbs(input logic [2:0] m);
    return (m[2] == 1'b0);
  endfunction

  function automatic logic pat_is_lfsr(input logic [2:0] m);
    return (m <= PAT_TGL);
  endfunction

  function automatic int pat_order(input logic [2:0] m);
    case (m)
      PAT_P7:  return 7;
      PAT_P15: return 15;
      PAT_P23: return 23;
      PAT_P31: return 31;
      PAT_TGL: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int pat_seed_words(input logic [2:0] m, input int dw);
    int n;
    n = (pat_order(m) + dw - 1) / dw;
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic logic [STW-1:0] pat_mask(input logic [2:0] m);
    case (m)
      PAT_P7:  return 31'h0000_007F;
      PAT_P15: return 31'h0000_7FFF;
      PAT_P23: return 31'h007F_FFFF;
      PAT_P31: return 31'h7FFF_FFFF;
      PAT_TGL: return 31'h0000_0001;
      default: return '0;
    endcase
  endfunction

  // New sequence bit from the current state; it is also shifted into bit 0.
  function automatic logic pat_fb(input logic [STW-1:0] s, input logic [2:0] m);
    case (m)
      PAT_P7:  return s[6]  ^ s[5];
      PAT_P15: return s[14] ^ s[13];
      PAT_P23: return s[22] ^ s[17];
      PAT_P31: return s[30] ^ s[27];
      PAT_TGL: return ~s[0];
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/prbs_bist_gen.sv
`timescale 1ns/1ps
module prbs_bist_gen
  import prbs_bist_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [2:0]    mode,
  input  logic [STW-1:0] seed,
  input  logic [DW-1:0] user_word,
  input  logic          inject,
  output logic [DW-1:0] tx_data
);
  logic           run_q;
  logic [2:0]     mode_q;
  logic [STW-1:0] st_q, st_d, start_st, src, st_w;
  logic [DW-1:0]  tx_q, tx_d, seq_w, word;
  logic           restart, fb;

  always_comb begin
    restart  = en && (!run_q || (mode != mode_q));
    start_st = seed & pat_mask(mode);
    if (mode == PAT_TGL) start_st = '0;
    else if (pat_is_prbs(mode) && (start_st == '0)) start_st = STW'(1);
    src  = restart ? start_st : st_q;
    st_w = src;
    for (int i = DW - 1; i >= 0; i--) begin
      fb       = pat_fb(st_w, mode);
      seq_w[i] = fb;
      st_w     = {st_w[STW-2:0], fb} & pat_mask(mode);
    end
    word = pat_is_lfsr(mode) ? seq_w : user_word;
    st_d = st_w;
    tx_d = en ? (word ^ DW'(inject)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      tx_q  <= '0;
    end else begin
      run_q <= en;
      tx_q  <= tx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      st_q   <= '0;
    end else if (en) begin
      mode_q <= mode;
      st_q   <= st_d;
    end
  end

  assign tx_data = tx_q;
endmodule

// File: rtl/prbs_bist_chk.sv
`timescale 1ns/1ps
module prbs_bist_chk
  import prbs_bist_pkg::*;
#(
  parameter int DW       = 16,
  parameter int LOCK_RUN = 16,
  parameter int DROP_RUN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [2:0]    mode,
  input  logic [DW-1:0] user_word,
  input  logic [DW-1:0] din,
  output logic          locked,
  output logic          err_add,
  output logic [DW-1:0] err_bits
);
  localparam int SCW = 6;
  localparam int GW  = $clog2(LOCK_RUN + 1);
  localparam int BW  = $clog2(DROP_RUN + 1);

  chk_ph_e        ph_q, ph_d;
  logic [2:0]     mode_q, mode_d;
  logic [STW-1:0] st_q, st_d, st_w, hist_n, seed_val;
  logic [SCW-1:0] scnt_q, scnt_d, need;
  logic [GW-1:0]  good_q, good_d;
  logic [BW-1:0]  bad_q, bad_d;
  logic           lock_q, lock_d;
  logic           restart, seed_ok, fb, word_bad, hist_we;
  logic [DW-1:0]  pred, exp_w, diff;

  // Seed history: the last STW received bits, newest in bit 0.
  generate
    if (DW >= STW) begin : g_hist_wide
      assign hist_n = din[STW-1:0];
    end else begin : g_hist_narrow
      localparam int HKW = STW - DW;
      logic [HKW-1:0] hist_q;
      assign hist_n = {hist_q, din};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hist_q <= '0;
        else if (hist_we) hist_q <= hist_n[HKW-1:0];
      end
    end
  endgenerate

  always_comb begin
    restart  = en && ((ph_q == PH_IDLE) || (mode != mode_q));
    hist_we  = en && !restart && (ph_q == PH_SEED);
    need     = SCW'(pat_seed_words(mode, DW));
    seed_val = hist_n & pat_mask(mode);
    seed_ok  = !pat_is_prbs(mode) || (seed_val != '0);
    st_w     = st_q;
    for (int i = DW - 1; i >= 0; i--) begin
      fb      = pat_fb(st_w, mode);
      pred[i] = fb;
      st_w    = {st_w[STW-2:0], fb} & pat_mask(mode);
    end
    exp_w    = pat_is_lfsr(mode) ? pred : user_word;
    diff     = din ^ exp_w;
    word_bad = |diff;
  end

  always_comb begin
    ph_d    = ph_q;
    mode_d  = mode_q;
    st_d    = st_q;
    scnt_d  = scnt_q;
    good_d  = good_q;
    bad_d   = bad_q;
    lock_d  = lock_q;
    err_add = 1'b0;
    if (!en) begin
      ph_d   = PH_IDLE;
      lock_d = 1'b0;
      good_d = '0;
      bad_d  = '0;
      scnt_d = '0;
    end else if (restart) begin
      ph_d   = PH_SEED;
      mode_d = mode;
      lock_d = 1'b0;
      good_d = '0;
      bad_d  = '0;
      scnt_d = '0;
    end else begin
      case (ph_q)
        PH_SEED: begin
          if ((scnt_q + SCW'(1)) >= need) begin
            if (seed_ok) begin
              st_d   = seed_val;
              ph_d   = PH_TRACK;
              scnt_d = '0;
            end
          end else begin
            scnt_d = scnt_q + SCW'(1);
          end
        end
        PH_TRACK: begin
          st_d    = st_w;
          err_add = lock_q;
          if (!word_bad) begin
            bad_d = '0;
            if (good_q == GW'(LOCK_RUN - 1)) lock_d = 1'b1;
            if (good_q != GW'(LOCK_RUN))     good_d = good_q + GW'(1);
          end else begin
            good_d = '0;
            if (bad_q == BW'(DROP_RUN - 1)) begin
              ph_d   = PH_SEED;
              lock_d = 1'b0;
              bad_d  = '0;
              scnt_d = '0;
            end else begin
              bad_d = bad_q + BW'(1);
            end
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      mode_q <= '0;
      st_q   <= '0;
      scnt_q <= '0;
      good_q <= '0;
      bad_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      mode_q <= mode_d;
      st_q   <= st_d;
      scnt_q <= scnt_d;
      good_q <= good_d;
      bad_q  <= bad_d;
      lock_q <= lock_d;
    end
  end

  assign locked   = lock_q;
  assign err_bits = diff;
endmodule

// File: rtl/prbs_bist_errcnt.sv
`timescale 1ns/1ps
module prbs_bist_errcnt #(
  parameter int DW = 16,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add,
  input  logic [DW-1:0] bits,
  output logic [CW-1:0] count
);
  localparam int PW = $clog2(DW + 1);

  logic [PW-1:0] pop;
  logic [CW:0]   sum;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_we;

  always_comb begin
    pop = '0;
    for (int i = 0; i < DW; i++) pop = pop + PW'(bits[i]);
    sum    = {1'b0, cnt_q} + (CW + 1)'(pop);
    cnt_we = clr || add;
    if (clr)          cnt_d = '0;
    else if (sum[CW]) cnt_d = '1;
    else              cnt_d = sum[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/prbs_bist.sv
`timescale 1ns/1ps
module prbs_bist
  import prbs_bist_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gen_en,
  input  logic          chk_en,
  input  logic [2:0]    mode,
  input  logic [30:0]   seed,
  input  logic [DW-1:0] user_word,
  input  logic          inject_err,
  input  logic          loopback,
  input  logic [DW-1:0] rx_data,
  input  logic          err_clr,
  output logic [DW-1:0] tx_data,
  output logic          locked,
  output logic [CW-1:0] err_count
);
  logic          rst_meta, rst_core;
  logic [DW-1:0] chk_din, err_bits;
  logic          err_add;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_core <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_core <= rst_meta;
    end
  end

  prbs_bist_gen #(.DW(DW)) u_gen (
    .clk       (clk),
    .rst_n     (rst_core),
    .en        (gen_en),
    .mode      (mode),
    .seed      (seed),
    .user_word (user_word),
    .inject    (inject_err),
    .tx_data   (tx_data)
  );

  assign chk_din = loopback ? tx_data : rx_data;

  prbs_bist_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_core),
    .en        (chk_en),
    .mode      (mode),
    .user_word (user_word),
    .din       (chk_din),
    .locked    (locked),
    .err_add   (err_add),
    .err_bits  (err_bits)
  );

  prbs_bist_errcnt #(.DW(DW), .CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_core),
    .clr   (err_clr),
    .add   (err_add),
    .bits  (err_bits),
    .count (err_count)
  );
endmodule

// File: rtl/prbs_bist_sva.sv
`timescale 1ns/1ps
module prbs_bist_sva #(
  parameter int DW = 16,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_core,
  input logic          gen_en,
  input logic          chk_en,
  input logic [2:0]    mode,
  input logic [DW-1:0] user_word,
  input logic          inject_err,
  input logic          err_clr,
  input logic [DW-1:0] tx_data,
  input logic          locked,
  input logic [CW-1:0] err_count
);
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_core)
    !gen_en |=> (tx_data == '0));

  p_user_repeat_r5: assert property (@(posedge clk) disable iff (!rst_core)
    (gen_en && (mode >= 3'd5) && !inject_err) |=> (tx_data == $past(user_word)));

  generate
    if (DW % 2 == 0) begin : g_tgl
      localparam logic [DW-1:0] ALT = {(DW/2){2'b10}};
      p_toggle_word_r4: assert property (@(posedge clk) disable iff (!rst_core)
        (gen_en && (mode == 3'd4) && !inject_err) |=> (tx_data == ALT));
    end
  endgenerate

  p_no_lock_off_r8: assert property (@(posedge clk) disable iff (!rst_core)
    !chk_en |=> !locked);

  p_lock_rise_r8: assert property (@(posedge clk) disable iff (!rst_core)
    $rose(locked) |-> $past(chk_en));

  p_unlocked_hold_r10: assert property (@(posedge clk) disable iff (!rst_core)
    (!locked && !err_clr) |=> $stable(err_count));

  p_no_decrease_r11: assert property (@(posedge clk) disable iff (!rst_core)
    !err_clr |=> (err_count >= $past(err_count)));

  p_sat_hold_r11: assert property (@(posedge clk) disable iff (!rst_core)
    ((&err_count) && !err_clr) |=> (&err_count));

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_core)
    err_clr |=> (err_count == '0));
endmodule

bind prbs_bist prbs_bist_sva #(.DW(DW), .CW(CW)) u_sva (.*);

// File: tb/tb_prbs_bist.sv
`timescale 1ns/1ps
module tb_prbs_bist;
  localparam int DW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n, gen_en, chk_en, inject_err, loopback, err_clr;
  logic [2:0]    mode;
  logic [30:0]   seed, gs, rs;
  logic [DW-1:0] user_word, rx_data, tx_data;
  logic          locked;
  logic [CW-1:0] err_count;
  int            checks = 0;
  int            errors = 0;
  bit            done = 0;

  always #4 clk = ~clk;

  prbs_bist #(.DW(DW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .chk_en(chk_en), .mode(mode),
    .seed(seed), .user_word(user_word), .inject_err(inject_err),
    .loopback(loopback), .rx_data(rx_data), .err_clr(err_clr),
    .tx_data(tx_data), .locked(locked), .err_count(err_count)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ord_of(input int m);
    case (m) 0: return 7; 1: return 15; 2: return 23; default: return 31; endcase
  endfunction

  function automatic int tap_of(input int m);
    case (m) 0: return 6; 1: return 14; 2: return 18; default: return 28; endcase
  endfunction

  function automatic logic [30:0] msk(input int m);
    return 31'h7FFF_FFFF >> (31 - ord_of(m));
  endfunction

  // Bit-serial reference: returns {next_state, word}, oldest bit in the MSB.
  function automatic logic [46:0] mword(input logic [30:0] s0, input int m);
    logic [30:0] s;
    logic [15:0] w;
    logic        b;
    s = s0;
    w = '0;
    for (int i = 0; i < 16; i++) begin
      b = s[ord_of(m) - 1] ^ s[tap_of(m) - 1];
      w = {w[14:0], b};
      s = {s[29:0], b} & msk(m);
    end
    return {s, w};
  endfunction

  task automatic feed(input logic [DW-1:0] w, input logic clr);
    rx_data = w;
    err_clr = clr;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  task automatic gen_cycle(input int m, input logic inj);
    logic [46:0] r;
    logic [15:0] e;
    inject_err = inj;
    @(negedge clk);
    inject_err = 1'b0;
    r  = mword(gs, m);
    gs = r[46:16];
    e  = r[15:0] ^ {15'd0, inj};
    chk(tx_data == e, "R12 flipped/sequence word", tx_data, e);
  endtask

  task automatic run_prbs(input int m, input logic [30:0] sd, input string lock_tag);
    logic [46:0] r;
    int need;
    mode = 3'(m); seed = sd; gen_en = 1'b1; chk_en = 1'b1; loopback = 1'b1;
    gs = sd & msk(m);
    if (gs == '0) gs = 31'd1;
    need = (ord_of(m) + 15) / 16;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      r  = mword(gs, m);
      gs = r[46:16];
      if (m == 0 && sd == '0 && k == 0) chk(tx_data == r[15:0], "R3 zero seed word", tx_data, r[15:0]);
      else chk(tx_data == r[15:0], "R2 sequence word", tx_data, r[15:0]);
      if (k == need + 15) chk(!locked, {lock_tag, " not yet locked"}, locked, 0);
      if (k == need + 16) chk(locked,  {lock_tag, " locked"}, locked, 1);
    end
    chk(err_count == '0, "R10 clean loopback count", err_count, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] w, e0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; gen_en = 1'b0; chk_en = 1'b0; inject_err = 1'b0; loopback = 1'b0;
    err_clr = 1'b0; mode = '0; seed = '0; user_word = '0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_data == '0, "R1 reset tx", tx_data, 0);
    chk(!locked, "R1 reset lock", locked, 0);
    chk(err_count == '0, "R1 reset count", err_count, 0);

    // R2 R3 R6 R8 R13: every order in loopback, mode changes restart both ends
    run_prbs(0, 31'd0, "R8");
    run_prbs(1, 31'($urandom()), "R13 R8");
    run_prbs(2, 31'($urandom()), "R13 R8");
    run_prbs(3, 31'($urandom()), "R13 R6");

    // R12: single-bit injection in order 31, loopback, locked
    e0 = DW'(err_count);
    gen_cycle(3, 1'b1);
    for (int i = 0; i < 4; i++) gen_cycle(3, 1'b0);
    chk(err_count == CW'(e0) + CW'(1), "R12 one error counted", err_count, e0 + 1);
    chk(locked, "R12 lock kept", locked, 1);

    // R4: toggle pattern
    mode = 3'd4;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(tx_data == 16'hAAAA, "R4 toggle word", tx_data, 16'hAAAA);
      if (k == 16) chk(!locked, "R8 toggle not yet", locked, 0);
      if (k == 17) chk(locked, "R8 toggle lock", locked, 1);
    end

    // R5: user word, codes 5 and 7
    user_word = 16'($urandom());
    mode = 3'd5;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(tx_data == user_word, "R5 user word", tx_data, user_word);
    end
    chk(locked, "R5 user lock", locked, 1);
    mode = 3'd7;
    @(negedge clk);
    chk(tx_data == user_word, "R5 code 7", tx_data, user_word);

    // R6 R7 R10: external stream, generator on another seed
    mode = 3'd1; seed = 31'h0000_1234; loopback = 1'b0; chk_en = 1'b0;
    @(negedge clk);
    chk(!locked, "R8 disabled", locked, 0);
    rs = 31'h0000_4C3B;
    chk_en = 1'b1;
    feed(16'hFFFF, 1'b1);                     // restart edge, clears counter
    begin
      logic [46:0] r;
      r = mword(rs, 1); rs = r[46:16]; feed(r[15:0], 1'b0);           // seed word
      for (int i = 0; i < 3; i++) begin r = mword(rs, 1); rs = r[46:16]; feed(r[15:0] ^ 16'h0101, 1'b0); end
      for (int i = 0; i < 16; i++) begin
        r = mword(rs, 1); rs = r[46:16];
        if (i == 15) chk(!locked, "R8 before 16th clean", locked, 0);
        feed(r[15:0], 1'b0);
      end
      chk(locked, "R6 locked on rx_data", locked, 1);
      chk(err_count == '0, "R10 nothing counted unlocked", err_count, 0);

      // R9: three bad words keep lock
      for (int i = 0; i < 3; i++) begin r = mword(rs, 1); rs = r[46:16]; feed(r[15:0] ^ 16'h0003, 1'b0); end
      chk(locked, "R9 three bad keep lock", locked, 1);
      chk(err_count == CW'(6), "R10 bit count", err_count, 6);
      r = mword(rs, 1); rs = r[46:16]; feed(r[15:0], 1'b0);
      for (int i = 0; i < 4; i++) begin
        r = mword(rs, 1); rs = r[46:16]; feed(r[15:0] ^ 16'h8000, 1'b0);
        if (i == 2) chk(locked, "R9 lock after 3 of 4", locked, 1);
      end
      chk(!locked, "R9 lock dropped", locked, 0);
      chk(err_count == CW'(10), "R10 counted while locked", err_count, 10);
      for (int i = 0; i < 17; i++) begin
        r = mword(rs, 1); rs = r[46:16];
        if (i == 16) chk(!locked, "R9 reseed not yet", locked, 0);
        feed(r[15:0], 1'b0);
      end
      chk(locked, "R9 relock after reseed", locked, 1);

      // R11: saturation and clear priority
      for (int b = 0; b < 6; b++) begin
        for (int i = 0; i < 3; i++) begin r = mword(rs, 1); rs = r[46:16]; feed(~r[15:0], 1'b0); end
        r = mword(rs, 1); rs = r[46:16]; feed(r[15:0], 1'b0);
      end
      chk(err_count == '1, "R11 saturated", err_count, 8'hFF);
      chk(locked, "R11 lock kept in bursts", locked, 1);
      for (int i = 0; i < 3; i++) begin r = mword(rs, 1); rs = r[46:16]; feed(~r[15:0], 1'b0); end
      chk(err_count == '1, "R11 stays saturated", err_count, 8'hFF);
      r = mword(rs, 1); rs = r[46:16]; feed(r[15:0], 1'b0);
      r = mword(rs, 1); rs = r[46:16]; feed(~r[15:0], 1'b1);
      chk(err_count == '0, "R11 clear wins", err_count, 0);
    end

    // R7: all-zero stream never locks in a PRBS mode
    chk_en = 1'b0;
    feed('0, 1'b0);
    chk_en = 1'b1;
    for (int i = 0; i < 40; i++) feed('0, 1'b0);
    chk(!locked, "R7 zero stream no lock", locked, 0);
    chk(err_count == '0, "R7 zero stream no count", err_count, 0);

    // R1: generator disabled gives zero
    gen_en = 1'b0;
    @(negedge clk);
    w = tx_data;
    chk(w == '0, "R1 disabled tx", w, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule